// File: doc/BRIEF.md
# DDR2 Precharge Timing Guard

This block sits beside a DDR2 memory controller and watches the command stream it sends to an eight-bank device. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines into activate, read, write and precharge commands. It keeps, for every bank, an open/closed flag and the number of clocks left before a precharge to that bank becomes legal. It also keeps the number of clocks left before a new activate is allowed after a precharge.

The controller sets a bank index and the all-banks select line, and the guard tells it two things at once. It reports whether a precharge with those settings could issue in the current cycle. It also reports which banks that precharge would close. The read and write latencies, the burst length and the tRTP, tWR, tRAS and tRP spacings are runtime inputs counted in clock cycles. When the guard sees a precharge or activate that breaks a timing window, it raises a one-cycle violation flag and names the bank involved.

Top module: `ddr2_pg_top`

## Requirements
- R1: Commands are decoded from {csN,rasN,casN,weN} at the rising edge: 0011 activate, 0101 read, 0100 write, 0010 precharge. Any pattern with csN high has no effect on bank state. An activate marks the addressed bank open from the next cycle.
- R2: With a10 high, closeMask is all ones, whatever bankAddr holds. A precharge then closes every bank.
- R3: With a10 low, closeMask has only bit bankAddr set (bank 0 to 7). A precharge then closes only that bank.
- R4: A read to a bank in cycle t makes a precharge to that bank illegal before cycle t + AL + BL/2 + max(tRTP,2) − 2. preOk reports this.
- R5: A write to a bank in cycle t makes a precharge to that bank illegal before cycle t + WL + BL/2 + tWR.
- R6: An activate to a bank in cycle t makes a precharge to that bank illegal before cycle t + tRAS.
- R7: A precharge that closes an open bank in cycle t makes an activate to that bank illegal before cycle t + tRP.
- R8: When several constraints apply to one bank, the latest one governs. A later command with a shorter window never makes the precharge legal sooner.
- R9: burstLen8 = 1 selects burst length 8 (BL/2 = 4). burstLen8 = 0 selects burst length 4 (BL/2 = 2).
- R10: An all-bank precharge is allowed (preOk = 1) only when every bank meets its constraint. An illegal one reports the lowest-numbered offending bank.
- R11: An illegal precharge or activate in cycle t sets violation high for exactly cycle t+1, with violBank holding the offending bank.
- R12: After reset all banks are closed, every counter is clear, preOk is 1 and violation is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 3 | Bank index |
| a10 | input | 1 | All-banks select for precharge |
| addLat | input | 5 | Additive latency, clocks |
| wrLat | input | 5 | Write latency, clocks |
| burstLen8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| tRtp | input | 5 | Read-to-precharge time, clocks |
| tWr | input | 5 | Write recovery time, clocks |
| tRas | input | 5 | Activate-to-precharge time, clocks |
| tRp | input | 5 | Precharge-to-activate time, clocks |
| preOk | output | 1 | A precharge with the present bankAddr/a10 is legal now |
| closeMask | output | 8 | Banks that such a precharge would close |
| bankOpen | output | 8 | Open flag per bank |
| violation | output | 1 | One-cycle flag for an illegal precharge or activate |
| violBank | output | 3 | Bank that caused the violation |

## Verification
The bench builds the guard with its default parameters: eight banks and 5-bit timing inputs. With these values a single rule can reach 66 clocks, so the 7-bit per-bank counters are exercised well above the smallest windows. The vector table covers both burst lengths and a tRTP below 2, which brings the clamp into play. It also covers read and write windows from 2 to 14 clocks, each sampled one cycle before and exactly at the edge of legality. Directed cases cover overlapping windows, an all-bank precharge with two offending banks, an early precharge and an early activate.

// File: rtl/ddr2_pg_pkg.sv
package ddr2_pg_pkg;
  // Decoded command strobes passed from control to the bank datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
  } cmdStrobe_t;
endpackage

// File: rtl/ddr2_pg_ctrl.sv
module ddr2_pg_ctrl
  import ddr2_pg_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 5,
  parameter int BA_W      = 3,
  parameter int CNT_W     = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      bankAddr,
  input  logic                 a10,
  input  logic [TIME_W-1:0]    addLat,
  input  logic [TIME_W-1:0]    wrLat,
  input  logic                 burstLen8,
  input  logic [TIME_W-1:0]    tRtp,
  input  logic [TIME_W-1:0]    tWr,
  input  logic [TIME_W-1:0]    tRas,
  input  logic [NUM_BANKS-1:0] preReady,
  input  logic [NUM_BANKS-1:0] actReady,
  output cmdStrobe_t           strobe,
  output logic [CNT_W-1:0]     cmdLoad,
  output logic [NUM_BANKS-1:0] closeMask,
  output logic                 preOk,
  output logic                 violation,
  output logic [BA_W-1:0]      violBank
);
  logic [CNT_W-1:0]     halfBurst;
  logic [CNT_W-1:0]     rtpEff;
  logic [CNT_W-1:0]     rdRule;
  logic [CNT_W-1:0]     wrRule;
  logic [NUM_BANKS-1:0] bankHot;
  logic [NUM_BANKS-1:0] offend;
  logic [BA_W-1:0]      firstIdx;

  // Command decode
  always_comb begin
    strobe.act = !csN && !rasN &&  casN &&  weN;
    strobe.rd  = !csN &&  rasN && !casN &&  weN;
    strobe.wr  = !csN &&  rasN && !casN && !weN;
    strobe.pre = !csN && !rasN &&  casN && !weN;
  end

  // Timing rule arithmetic
  always_comb begin
    halfBurst = burstLen8 ? CNT_W'(4) : CNT_W'(2);
    rtpEff    = (tRtp < TIME_W'(2)) ? CNT_W'(2) : CNT_W'(tRtp);
    rdRule    = CNT_W'(addLat) + halfBurst + rtpEff - CNT_W'(2);
    wrRule    = CNT_W'(wrLat) + halfBurst + CNT_W'(tWr);
    if (strobe.act)     cmdLoad = CNT_W'(tRas);
    else if (strobe.rd) cmdLoad = rdRule;
    else                cmdLoad = wrRule;
  end

  // Bank selection and legality
  always_comb begin
    bankHot   = NUM_BANKS'(1) << bankAddr;
    closeMask = a10 ? {NUM_BANKS{1'b1}} : bankHot;
    preOk     = &(preReady | ~closeMask);
    if (strobe.pre)      offend = closeMask & ~preReady;
    else if (strobe.act) offend = bankHot & ~actReady;
    else                 offend = '0;
    firstIdx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (offend[b]) firstIdx = BA_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violation <= 1'b0;
      violBank  <= '0;
    end else begin
      violation <= |offend;
      violBank  <= firstIdx;
    end
  end
endmodule

// File: rtl/ddr2_pg_bank_dp.sv
module ddr2_pg_bank_dp
  import ddr2_pg_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 5,
  parameter int BA_W      = 3,
  parameter int CNT_W     = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdStrobe_t           strobe,
  input  logic [BA_W-1:0]      bankAddr,
  input  logic [NUM_BANKS-1:0] closeMask,
  input  logic [CNT_W-1:0]     cmdLoad,
  input  logic [TIME_W-1:0]    tRp,
  output logic [NUM_BANKS-1:0] preReady,
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] bankOpen
);
  logic [CNT_W-1:0]  loadDec;
  logic [TIME_W-1:0] rpDec;

  assign loadDec = (cmdLoad == '0) ? '0 : cmdLoad - CNT_W'(1);
  assign rpDec   = (tRp == '0) ? '0 : tRp - TIME_W'(1);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic [CNT_W-1:0]  preCnt;
    logic [TIME_W-1:0] actCnt;
    logic [CNT_W-1:0]  preDec;
    logic [TIME_W-1:0] actDec;
    logic              hitCmd;
    logic              closeHit;

    assign preDec   = (preCnt == '0) ? '0 : preCnt - CNT_W'(1);
    assign actDec   = (actCnt == '0) ? '0 : actCnt - TIME_W'(1);
    assign hitCmd   = (strobe.act || strobe.rd || strobe.wr) && (bankAddr == BA_W'(i));
    assign closeHit = strobe.pre && closeMask[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preCnt      <= '0;
        actCnt      <= '0;
        bankOpen[i] <= 1'b0;
      end else if (closeHit) begin
        preCnt      <= '0;
        actCnt      <= bankOpen[i] ? rpDec : actDec;
        bankOpen[i] <= 1'b0;
      end else begin
        actCnt <= actDec;
        if (hitCmd) preCnt <= (loadDec > preDec) ? loadDec : preDec;
        else        preCnt <= preDec;
        if (hitCmd && strobe.act) bankOpen[i] <= 1'b1;
      end
    end

    assign preReady[i] = (preCnt == '0);
    assign actReady[i] = (actCnt == '0);
  end
endmodule

// File: rtl/ddr2_pg_top.sv
module ddr2_pg_top
  import ddr2_pg_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          rasN,
  input  logic                          casN,
  input  logic                          weN,
  input  logic [$clog2(NUM_BANKS)-1:0]  bankAddr,
  input  logic                          a10,
  input  logic [TIME_W-1:0]             addLat,
  input  logic [TIME_W-1:0]             wrLat,
  input  logic                          burstLen8,
  input  logic [TIME_W-1:0]             tRtp,
  input  logic [TIME_W-1:0]             tWr,
  input  logic [TIME_W-1:0]             tRas,
  input  logic [TIME_W-1:0]             tRp,
  output logic                          preOk,
  output logic [NUM_BANKS-1:0]          closeMask,
  output logic [NUM_BANKS-1:0]          bankOpen,
  output logic                          violation,
  output logic [$clog2(NUM_BANKS)-1:0]  violBank
);
  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int CNT_W = TIME_W + 2;

  cmdStrobe_t           strobe;
  logic [CNT_W-1:0]     cmdLoad;
  logic [NUM_BANKS-1:0] preReady;
  logic [NUM_BANKS-1:0] actReady;

  ddr2_pg_ctrl #(
    .NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W), .BA_W(BA_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .a10(a10), .addLat(addLat), .wrLat(wrLat),
    .burstLen8(burstLen8), .tRtp(tRtp), .tWr(tWr), .tRas(tRas),
    .preReady(preReady), .actReady(actReady), .strobe(strobe),
    .cmdLoad(cmdLoad), .closeMask(closeMask), .preOk(preOk),
    .violation(violation), .violBank(violBank)
  );

  ddr2_pg_bank_dp #(
    .NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W), .BA_W(BA_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankAddr(bankAddr),
    .closeMask(closeMask), .cmdLoad(cmdLoad), .tRp(tRp),
    .preReady(preReady), .actReady(actReady), .bankOpen(bankOpen)
  );
endmodule

// File: rtl/ddr2_pg_checker.sv
module ddr2_pg_checker #(
  parameter int NUM_BANKS = 8,
  parameter int BA_W      = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 rasN,
  input logic                 casN,
  input logic                 weN,
  input logic [BA_W-1:0]      bankAddr,
  input logic                 a10,
  input logic [NUM_BANKS-1:0] closeMask,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 violation
);
  AST_ALL_BANKS_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN && a10) |=> (bankOpen == '0)); // R2

  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && weN) |=> bankOpen[$past(bankAddr)]); // R1

  AST_SINGLE_BANK_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !a10 |-> ($countones(closeMask) == 1)); // R3

  AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> $past(!csN && !rasN && casN)); // R11

  AST_NOCMD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (bankOpen == $past(bankOpen))); // R1
endmodule

bind ddr2_pg_top ddr2_pg_checker #(
  .NUM_BANKS(NUM_BANKS), .BA_W($clog2(NUM_BANKS))
) checker_i (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .bankAddr(bankAddr), .a10(a10), .closeMask(closeMask),
  .bankOpen(bankOpen), .violation(violation)
);

// File: tb/ddr2_pg_top_tb_top.sv
module ddr2_pg_top_tb_top;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_NOP = 4'b1111;

  typedef struct packed {
    logic       isWr;
    logic [4:0] lat;
    logic [4:0] tim;
    logic       bl8;
    logic [7:0] expN;
  } vec_t;

  // Expected window N, worked out by hand from R4/R5/R9
  localparam vec_t VECS [6] = '{
    '{1'b0, 5'd0, 5'd2, 1'b0, 8'd2},   // read 0+2+2-2
    '{1'b0, 5'd3, 5'd5, 1'b1, 8'd10},  // read 3+4+5-2
    '{1'b0, 5'd1, 5'd0, 1'b0, 8'd3},   // read tRTP clamped to 2
    '{1'b1, 5'd2, 5'd3, 1'b0, 8'd7},   // write 2+2+3
    '{1'b1, 5'd4, 5'd6, 1'b1, 8'd14},  // write 4+4+6
    '{1'b0, 5'd0, 5'd1, 1'b1, 8'd4}    // read BL8, clamp
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [2:0] bankAddr = '0;
  logic a10 = 1'b0;
  logic [4:0] addLat = '0, wrLat = '0, tRtp = 5'd2, tWr = 5'd1, tRas = 5'd1, tRp = 5'd1;
  logic burstLen8 = 1'b0;
  logic preOk, violation;
  logic [7:0] closeMask, bankOpen;
  logic [2:0] violBank;
  int nChecks = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  ddr2_pg_top dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .a10(a10), .addLat(addLat), .wrLat(wrLat),
    .burstLen8(burstLen8), .tRtp(tRtp), .tWr(tWr), .tRas(tRas), .tRp(tRp),
    .preOk(preOk), .closeMask(closeMask), .bankOpen(bankOpen),
    .violation(violation), .violBank(violBank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Each task starts and ends 1 ns after a rising edge
  task automatic cmd(input logic [3:0] pins, input logic [2:0] bank, input logic sel);
    {csN, rasN, casN, weN} = pins;
    bankAddr = bank;
    a10 = sel;
    @(posedge clk); #1;
    {csN, rasN, casN, weN} = C_NOP;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic probe(input logic [2:0] bank, input logic sel);
    bankAddr = bank;
    a10 = sel;
    #2;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {csN, rasN, casN, weN} = C_NOP;
    @(posedge clk); @(posedge clk); #1;
    rstN = 1'b1;
    skip(1);
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    doReset();
    // R12: reset state
    probe(3'd0, 1'b1);
    chk("R12 bankOpen", bankOpen, 8'h00);
    chk("R12 preOk", preOk, 1);
    chk("R12 violation", violation, 0);

    // Table walk: R4, R5, R9 windows
    foreach (VECS[v]) begin
      doReset();
      tRas = 5'd1;
      burstLen8 = VECS[v].bl8;
      if (VECS[v].isWr) begin
        wrLat = VECS[v].lat; tWr = VECS[v].tim;
      end else begin
        addLat = VECS[v].lat; tRtp = VECS[v].tim;
      end
      cmd(C_ACT, 3'd2, 1'b0);
      cmd(VECS[v].isWr ? C_WR : C_RD, 3'd2, 1'b0);
      skip(int'(VECS[v].expN) - 2);
      probe(3'd2, 1'b0);
      chk(VECS[v].isWr ? "R5 early" : "R4/R9 early", preOk, 0);
      skip(1);
      probe(3'd2, 1'b0);
      chk(VECS[v].isWr ? "R5 edge" : "R4/R9 edge", preOk, 1);
    end

    // R1: activate opens, csN high ignored
    doReset();
    addLat = 5'd3; tRtp = 5'd5; wrLat = 5'd4; tWr = 5'd6; burstLen8 = 1'b1;
    tRas = 5'd1; tRp = 5'd1;
    cmd(C_ACT, 3'd5, 1'b0);
    probe(3'd0, 1'b0);
    chk("R1 act open", bankOpen, 8'h20);
    cmd(4'b1010, 3'd5, 1'b1);
    probe(3'd0, 1'b0);
    chk("R1 csN high ignored", bankOpen, 8'h20);

    // R3: single-bank mask and close
    probe(3'd3, 1'b0);
    chk("R3 mask", closeMask, 8'h08);
    cmd(C_ACT, 3'd2, 1'b0);
    cmd(C_PRE, 3'd2, 1'b0);
    probe(3'd0, 1'b0);
    chk("R3 close one", bankOpen, 8'h20);

    // R2: all-bank mask and close
    probe(3'd2, 1'b1);
    chk("R2 mask", closeMask, 8'hFF);
    cmd(C_PRE, 3'd2, 1'b1);
    probe(3'd0, 1'b0);
    chk("R2 close all", bankOpen, 8'h00);

    // R6: tRAS window, then early precharge -> R11
    doReset();
    tRas = 5'd6;
    cmd(C_ACT, 3'd1, 1'b0);
    skip(4);
    probe(3'd1, 1'b0);
    chk("R6 early", preOk, 0);
    skip(1);
    probe(3'd1, 1'b0);
    chk("R6 edge", preOk, 1);
    cmd(C_ACT, 3'd4, 1'b0);
    skip(1);
    cmd(C_PRE, 3'd4, 1'b0);
    probe(3'd0, 1'b0);
    chk("R11 viol", violation, 1);
    chk("R11 bank", violBank, 3'd4);
    skip(1);
    chk("R11 pulse", violation, 0);

    // R7: tRP after precharge of open bank
    doReset();
    tRas = 5'd1; tRp = 5'd4;
    cmd(C_ACT, 3'd6, 1'b0);
    cmd(C_PRE, 3'd6, 1'b0);
    skip(1);
    cmd(C_ACT, 3'd6, 1'b0);
    chk("R7 early act viol", violation, 1);
    chk("R7 early act bank", violBank, 3'd6);
    cmd(C_PRE, 3'd6, 1'b0);
    skip(3);
    cmd(C_ACT, 3'd6, 1'b0);
    chk("R7 act at tRP legal", violation, 0);

    // R10: all-bank precharge, lowest offender
    doReset();
    tRas = 5'd1; tRp = 5'd1; addLat = 5'd3; tRtp = 5'd5; burstLen8 = 1'b1;
    cmd(C_ACT, 3'd3, 1'b0);
    cmd(C_ACT, 3'd6, 1'b0);
    cmd(C_RD, 3'd6, 1'b0);
    cmd(C_RD, 3'd3, 1'b0);
    probe(3'd0, 1'b1);
    chk("R10 all blocked", preOk, 0);
    probe(3'd0, 1'b0);
    chk("R10 idle bank ok", preOk, 1);
    cmd(C_PRE, 3'd0, 1'b1);
    chk("R10 viol", violation, 1);
    chk("R10 lowest bank", violBank, 3'd3);

    // R8: write (N=14) then read (N=10) one cycle later
    doReset();
    tRas = 5'd1; wrLat = 5'd4; tWr = 5'd6; addLat = 5'd3; tRtp = 5'd5; burstLen8 = 1'b1;
    cmd(C_ACT, 3'd1, 1'b0);
    cmd(C_WR, 3'd1, 1'b0);
    cmd(C_RD, 3'd1, 1'b0);
    skip(9);
    probe(3'd1, 1'b0);
    chk("R8 read edge still blocked", preOk, 0);
    skip(2);
    probe(3'd1, 1'b0);
    chk("R8 write window", preOk, 0);
    skip(1);
    probe(3'd1, 1'b0);
    chk("R8 write edge", preOk, 1);

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule